// File: doc/BRIEF.md
# Shift-Window Push-Button Debouncer

This block turns the bouncing level from a mechanical push-button into a clean level that the rest of a design can trust. The raw pin is first brought into the clock domain through a short flop chain. A free-running prescale counter then produces a one-cycle sample enable each time its top bit goes from zero to one. On each enable, the synchronized level is shifted into a window of recent samples. The clean output is the AND of every bit in that window.

A press is therefore reported only after a full window of consecutive high samples. A release, or any single low sample, pulls the output down at once. With the default 16-bit counter and a 50 MHz clock, samples arrive about every 1.31 ms (about 763 Hz), so a press must hold for about 10.5 ms before the output rises. Everything runs on the one system clock. The prescaler is a clock enable, not a derived clock.

Top module: `shift_window_debouncer`

## Requirements
- R1: While `rst` is high at a clock edge, the window and the counter are cleared, so `btn_clean` reads 0 in the following cycle. It stays 0 until WIN sample enables have each taken in a high sample.
- R2: A sample enable occurs at the edge after the counter first reaches 2^(CNT_W-1), and then once every 2^CNT_W cycles. With raw held high from reset release, `btn_clean` rises right after non-reset edge number 2^(CNT_W-1)+1+(WIN-1)·2^CNT_W.
- R3: The value shifted in at a sample edge is the level `btn_raw` had at the clock edge SYNC_STAGES edges earlier, which is two edges with the default.
- R4: `btn_clean` is 1 exactly when all WIN window bits are 1. It can only rise in the cycle just after a sample enable.
- R5: While `btn_clean` is high, a single low sample drops it at that sample edge. It rises again only after WIN further consecutive high samples.
- R6: Changes of `btn_raw` that fall between sample points and are not captured have no effect on `btn_clean`.
- R7: A reset applied while `btn_clean` is high forces it low in the next cycle. A full window of fresh high samples is needed before it rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Asynchronous level from the button |
| btn_clean | output | 1 | Debounced button level |

## Verification
A corrupted window bit shows at `btn_clean` as a missed or spurious press that lasts until the bad bit shifts out, which takes up to WIN sample periods. A prescaler fault shifts the rise time away from the exact edge given in R2. Both faults therefore appear within one full window of samples. The bench compares the output on every cycle against an independent sample-point model, so a wrong bit is reported in the cycle it first shows at the port.

// File: rtl/shift_window_debouncer.sv
module shift_window_debouncer #(
  parameter int CNT_W       = 16,
  parameter int WIN         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic btn_clean
);

  localparam int MSB = CNT_W - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt;
  logic                   msb_q;
  logic                   tick;
  logic                   synced;
  logic [WIN-1:0]         hist;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], btn_raw};
  end

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      msb_q <= 1'b0;
    end else begin
      cnt   <= cnt + 1'b1;
      msb_q <= cnt[MSB];
    end
  end

  assign tick = cnt[MSB] & ~msb_q;

  always_ff @(posedge clk) begin
    if (rst)       hist <= '0;
    else if (tick) hist <= {hist[WIN-2:0], synced};
  end

  assign btn_clean = &hist;

endmodule

module shift_window_debouncer_chk #(
  parameter int WIN = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic           synced,
  input logic [WIN-1:0] hist,
  input logic           btn_clean
);

  assert_low_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !btn_clean);

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_sample_source_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> hist[0] == $past(synced));

  assert_rise_after_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(btn_clean) |-> $past(tick));

  assert_drop_on_low_R5: assert property (@(posedge clk) disable iff (rst)
    (btn_clean && tick && !synced) |=> !btn_clean);

  assert_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
    (!tick && !rst) |=> $stable(hist));

endmodule

bind shift_window_debouncer shift_window_debouncer_chk #(.WIN(WIN)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .synced(synced),
  .hist(hist), .btn_clean(btn_clean)
);

// File: tb/shift_window_debouncer_bench.sv
`timescale 1ns/1ps
module shift_window_debouncer_bench;
  localparam int CW  = 6;
  localparam int P   = 1 << CW;
  localparam int WIN = 8;
  localparam int SH  = P/2 + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b0;
  logic btn_clean;

  int vectors = 0;
  int miscompares = 0;
  int n = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;
  logic s1 = 1'b0, s2 = 1'b0;
  logic [WIN-1:0] h = '0;

  always #2 clk = ~clk;

  shift_window_debouncer #(.CNT_W(CW), .WIN(WIN), .SYNC_STAGES(2)) u_shift_window_debouncer (
    .clk(clk), .rst(rst), .btn_raw(btn_raw), .btn_clean(btn_clean)
  );

  function automatic logic exp_clean(input logic [WIN-1:0] w);
    return &w;
  endfunction

  function automatic bit is_sample_edge(input int k);
    return (k % P) == SH;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      n <= 0; s1 <= 1'b0; s2 <= 1'b0; h <= '0;
    end else begin
      n  <= n + 1;
      s1 <= btn_raw;
      s2 <= s1;
      if (is_sample_edge(n + 1)) h <= {h[WIN-2:0], s2};
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: btn_clean=%b expected %b at t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on && !done) chk("R3 R4 model", btn_clean, exp_clean(h));

  task automatic wait_phase(input int k);
    do @(negedge clk); while ((n % P) != k);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd7141));
    repeat (3) @(negedge clk);
    chk("R1 reset", btn_clean, 1'b0);
    btn_raw = 1'b1;
    rst = 1'b0;
    model_on = 1'b1;
    repeat (SH + (WIN-1)*P - 1) @(posedge clk);
    @(negedge clk); chk("R2 before rise", btn_clean, 1'b0);
    @(negedge clk); chk("R2 rise edge", btn_clean, 1'b1);

    wait_phase(40); btn_raw = 1'b0;
    repeat (10) @(negedge clk);
    btn_raw = 1'b1;
    wait_phase(60); chk("R6 glitch ignored", btn_clean, 1'b1);

    wait_phase(20); btn_raw = 1'b0;
    wait_phase(40); chk("R5 drop", btn_clean, 1'b0);
    btn_raw = 1'b1;
    for (int i = 0; i < WIN-1; i++) begin
      wait_phase(40); chk("R5 still low", btn_clean, 1'b0);
    end
    wait_phase(40); chk("R5 recover", btn_clean, 1'b1);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); chk("R7 reset high", btn_clean, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < WIN-1; i++) begin
      wait_phase(40); chk("R7 refill", btn_clean, 1'b0);
    end
    wait_phase(40); chk("R7 refilled", btn_clean, 1'b1);

    for (int seg = 0; seg < 60; seg++) begin
      int kind = $urandom % 4;
      int len  = 1 + ($urandom % 1100);
      if (kind == 0) begin
        for (int c = 0; c < (len % 120) + 1; c++) begin
          @(negedge clk); btn_raw = $urandom % 2;
        end
      end else if (kind == 3 && seg % 15 == 0) begin
        do_reset();
      end else begin
        @(negedge clk); btn_raw = (kind != 2);
        repeat (len) @(negedge clk);
      end
    end

    btn_raw = 1'b0;
    wait_phase(40); chk("R4 released", btn_clean, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule